// File: doc/BRIEF.md
# Configurable SPI Shift Engine

This block moves one data word (eight bits by default) in both directions at once over a four-wire serial link. It can act as the clock-driving master or as the clock-following slave. The register bank supplies the configuration bits, the word to send and a start strobe. A baud generator supplies `edge_tick`, and each tick marks one half-bit step. When a transfer ends, the block returns the received word with a one-cycle `done` pulse. A master that senses a conflicting select pulses `mode_fault` and gives up the link.

Five inputs set how the link runs. Clock polarity and phase give all four timing variants. The bit order can be MSB first or LSB first. In single-wire mode each role moves its data on one pin, and a direction bit sets whether that pin is driven. The master's select pin has two control bits. With them it can be left alone, driven automatically around each transfer, or watched as a fault input. In slave mode the select pin is always the active-low chip select.

The controller is a state machine with these states:
- `ST_IDLE`: waiting for work.
- `ST_M_LEAD`: the master waits one tick, then asserts select.
- `ST_M_SHIFT`: the master makes 16 clock edges, one per tick.
- `ST_M_TAIL`: one tick after the last edge, then select is released.
- `ST_S_SHIFT`: the slave follows the external clock while it is selected.
- `ST_DONE`: a single cycle that carries the result.

The transitions are:
- `ST_IDLE` goes to `ST_M_LEAD` when a master sees `start`.
- `ST_IDLE` goes to `ST_S_SHIFT` when a slave sees select fall.
- `ST_M_LEAD` goes to `ST_M_SHIFT` on a tick.
- `ST_M_SHIFT` goes to `ST_M_TAIL` on the 16th edge.
- `ST_M_TAIL` goes to `ST_DONE` on a tick.
- `ST_S_SHIFT` goes to `ST_DONE` after 16 edges and the final shift.
- `ST_S_SHIFT` goes back to `ST_IDLE` if select rises early.
- `ST_DONE` goes to `ST_IDLE`.
- Any state goes to `ST_IDLE` on disable or on a mode fault.

Top module: `spi_shift_core`

## Requirements
- R1: With `lsb_first`=0 the word leaves bit 7 first and the received word is filled from bit 7 downward. With `lsb_first`=1 bit 0 leaves first and the received word is filled from bit 0 upward.
- R2: While an enabled master is idle, `sck_out` equals `cpol`. A master transfer makes exactly 16 `sck_out` edges, one per `edge_tick`.
- R3: With `cpha`=0 the first bit is on the data output before the first edge. Data is sampled on edges 1,3,5,… and changed on edges 2,4,…. With `cpha`=1 data changes on edges 1,3,… and is sampled on edges 2,4,….
- R4: In normal pin mode the master drives `mosi_out` and samples `miso_in`, and ignores `mosi_in`. A selected slave drives `miso_out` and samples `mosi_in`, and ignores `miso_in`. The master never enables `miso_oe`, and a slave never enables `sck_oe` or `mosi_oe`.
- R5: In single-wire mode the master uses only the MOSI pin and the slave uses only the MISO pin. That pin's output enable follows `pin_oe`. With `pin_oe`=0 the data is received on that same pin and the other pin is ignored.
- R6: For a master with `fault_en`=1 and `ss_out_en`=1, `ss_oe`=1. `ss_out` goes low one tick before the first clock edge and high again one tick after the last edge, and it is high during `done`.
- R7: For a master with `fault_en`=1 and `ss_out_en`=0, a low `ss_in` aborts the transfer with no `done`. `mode_fault` pulses for one cycle, and `as_master` drops, which turns off `sck_oe` and `mosi_oe`. The block stays a slave until `is_master` is taken low.
- R8: For a master with `fault_en`=0, `ss_oe`=0 and `ss_in` has no effect on a transfer.
- R9: A slave with `ss_in` high drives nothing and ignores `sck_in`. When `ss_in` falls it loads `tx_byte`. With `cpha`=0 it places its first bit on `miso_out` before any clock edge.
- R10: `done` is a single-cycle pulse after the 16th edge, and `rx_byte` holds the received word in that cycle. `start` is ignored unless the block is an idle, enabled master.
- R11: With `enable`=0 every output enable is low and `start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Engine enable |
| is_master | input | 1 | 1 = master role requested |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | Clock phase select |
| lsb_first | input | 1 | 1 = bit 0 first |
| one_wire | input | 1 | Single-wire data mode |
| pin_oe | input | 1 | Data pin drive enable in single-wire mode |
| fault_en | input | 1 | Master select pin under engine control |
| ss_out_en | input | 1 | 1 = automatic select output, 0 = fault input |
| tx_byte | input | DATA_W | Word to send |
| start | input | 1 | Master transfer request strobe |
| edge_tick | input | 1 | Half-bit tick from the baud generator |
| sck_in | input | 1 | Serial clock pin input |
| sck_out | output | 1 | Serial clock pin output |
| sck_oe | output | 1 | Serial clock pin drive enable |
| mosi_in | input | 1 | MOSI pin input |
| mosi_out | output | 1 | MOSI pin output |
| mosi_oe | output | 1 | MOSI pin drive enable |
| miso_in | input | 1 | MISO pin input |
| miso_out | output | 1 | MISO pin output |
| miso_oe | output | 1 | MISO pin drive enable |
| ss_in | input | 1 | Select pin input |
| ss_out | output | 1 | Select pin output |
| ss_oe | output | 1 | Select pin drive enable |
| rx_byte | output | DATA_W | Received word, valid with `done` |
| done | output | 1 | Transfer complete pulse |
| mode_fault | output | 1 | Mode fault pulse |
| busy | output | 1 | Engine not idle |
| as_master | output | 1 | Engine currently acts as master |

## Verification
The assertions assume that the configuration inputs do not change while a transfer is running. They also assume that `edge_tick` is a single-cycle pulse. The bench changes configuration only between transfers, while `busy` is low, and gives each tick one cycle with five idle cycles between ticks. In slave tests the external clock and data each hold for eight block cycles, so the two-stage input synchroniser always settles between edges. Select is changed only while the clock is at its idle level.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_M_LEAD  = 3'd1,
        ST_M_SHIFT = 3'd2,
        ST_M_TAIL  = 3'd3,
        ST_S_SHIFT = 3'd4,
        ST_DONE    = 3'd5
    } eng_state_t;

endpackage

// File: rtl/spi_sync_bank.sv
module spi_sync_bank #(
    parameter int           N       = 3,
    parameter int           STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_bit
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= {STAGES{RST_VAL[gi]}};
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], d[gi]};
                end
            end
            assign q[gi] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/spi_shreg.sv
module spi_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         lsb_first,
    input  logic         sin,
    output logic         sout,
    output logic [W-1:0] q
);

    logic [W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= load_val;
        end else if (shift) begin
            if (lsb_first) begin
                sr_q <= {sin, sr_q[W-1:1]};
            end else begin
                sr_q <= {sr_q[W-2:0], sin};
            end
        end
    end

    assign sout = lsb_first ? sr_q[0] : sr_q[W-1];
    assign q    = sr_q;

endmodule

// File: rtl/spi_pin_route.sv
module spi_pin_route (
    input  logic enable,
    input  logic role_m,
    input  logic one_wire,
    input  logic pin_oe,
    input  logic slave_sel,
    input  logic sout,
    input  logic mosi_in,
    input  logic miso_in,
    output logic mosi_out,
    output logic mosi_oe,
    output logic miso_out,
    output logic miso_oe,
    output logic din_raw
);

    always_comb begin
        mosi_out = sout;
        miso_out = sout;
        if (role_m) begin
            mosi_oe = enable & (one_wire ? pin_oe : 1'b1);
            miso_oe = 1'b0;
            din_raw = one_wire ? mosi_in : miso_in;
        end else begin
            mosi_oe = 1'b0;
            miso_oe = enable & slave_sel & (one_wire ? pin_oe : 1'b1);
            din_raw = one_wire ? miso_in : mosi_in;
        end
    end

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
    import spi_eng_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              is_master,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              one_wire,
    input  logic              pin_oe,
    input  logic              fault_en,
    input  logic              ss_out_en,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              start,
    input  logic              edge_tick,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              mosi_in,
    output logic              mosi_out,
    output logic              mosi_oe,
    input  logic              miso_in,
    output logic              miso_out,
    output logic              miso_oe,
    input  logic              ss_in,
    output logic              ss_out,
    output logic              ss_oe,
    output logic [DATA_W-1:0] rx_byte,
    output logic              done,
    output logic              mode_fault,
    output logic              busy,
    output logic              as_master
);

    localparam int            EDGES     = 2 * DATA_W;
    localparam int            CW        = $clog2(EDGES + 1);
    localparam logic [CW-1:0] LAST_EDGE = CW'(EDGES - 1);
    localparam logic [CW-1:0] ALL_EDGES = CW'(EDGES);

    eng_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          sck_ph_q;
    logic          pend_q;
    logic          samp_q;
    logic          ss_drv_q;
    logic          demote_q;
    logic          fault_q;
    logic          sck_d_q;

    logic [2:0] sync_q;
    logic       sck_s, ss_s, din_s, din_raw;
    logic       role_m, fault_hit, abort;
    logic       m_edge, s_edge, edge_ev, samp_ev, shift_ev;
    logic       m_go, s_go, load, slave_sel, sout;

    // input synchroniser: clock, select, selected data pin
    spi_sync_bank #(
        .N      (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sck_in, ss_in, din_raw}),
        .q    (sync_q)
    );

    assign sck_s = sync_q[2];
    assign ss_s  = sync_q[1];
    assign din_s = sync_q[0];

    assign role_m    = is_master & ~demote_q;
    assign fault_hit = enable & role_m & fault_en & ~ss_out_en & ~ss_s;
    assign abort     = ~enable | fault_hit;

    assign m_edge   = (state_q == ST_M_SHIFT) & edge_tick;
    assign s_edge   = (state_q == ST_S_SHIFT) & (sck_s ^ sck_d_q);
    assign edge_ev  = m_edge | s_edge;
    // even edge index = leading edge; sample where parity matches cpha
    assign samp_ev  = edge_ev & (cnt_q[0] == cpha);
    assign shift_ev = pend_q & (state_q != ST_IDLE) & (edge_ev | (cnt_q == ALL_EDGES));

    assign m_go = (state_q == ST_IDLE) & enable & role_m & start & ~fault_hit;
    assign s_go = (state_q == ST_IDLE) & enable & ~role_m & ~ss_s;
    assign load = m_go | s_go;

    assign slave_sel = ~role_m & ((state_q == ST_S_SHIFT) | (state_q == ST_DONE));

    spi_shreg #(.W(DATA_W)) u_sr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (tx_byte),
        .shift    (shift_ev),
        .lsb_first(lsb_first),
        .sin      (samp_q),
        .sout     (sout),
        .q        (rx_byte)
    );

    spi_pin_route u_route (
        .enable   (enable),
        .role_m   (role_m),
        .one_wire (one_wire),
        .pin_oe   (pin_oe),
        .slave_sel(slave_sel),
        .sout     (sout),
        .mosi_in  (mosi_in),
        .miso_in  (miso_in),
        .mosi_out (mosi_out),
        .mosi_oe  (mosi_oe),
        .miso_out (miso_out),
        .miso_oe  (miso_oe),
        .din_raw  (din_raw)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (abort) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (m_go) begin
                        state_d = ST_M_LEAD;
                    end else if (s_go) begin
                        state_d = ST_S_SHIFT;
                    end
                end
                ST_M_LEAD: begin
                    if (edge_tick) state_d = ST_M_SHIFT;
                end
                ST_M_SHIFT: begin
                    if (edge_tick && cnt_q == LAST_EDGE) state_d = ST_M_TAIL;
                end
                ST_M_TAIL: begin
                    if (edge_tick) state_d = ST_DONE;
                end
                ST_S_SHIFT: begin
                    if (ss_s) begin
                        state_d = ST_IDLE;
                    end else if (cnt_q == ALL_EDGES && !pend_q) begin
                        state_d = ST_DONE;
                    end
                end
                ST_DONE: state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // edge bookkeeping, select drive, role and fault registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            sck_ph_q <= 1'b0;
            pend_q   <= 1'b0;
            samp_q   <= 1'b0;
            ss_drv_q <= 1'b0;
            demote_q <= 1'b0;
            fault_q  <= 1'b0;
            sck_d_q  <= 1'b0;
        end else begin
            sck_d_q <= sck_s;
            fault_q <= fault_hit;
            if (load) begin
                cnt_q    <= '0;
                pend_q   <= 1'b0;
                sck_ph_q <= 1'b0;
            end else begin
                if (edge_ev && cnt_q != ALL_EDGES) cnt_q <= cnt_q + CW'(1);
                if (samp_ev) begin
                    pend_q <= 1'b1;
                    samp_q <= din_s;
                end else if (shift_ev) begin
                    pend_q <= 1'b0;
                end
                if (m_edge) sck_ph_q <= ~sck_ph_q;
            end
            if (abort) sck_ph_q <= 1'b0;
            if (abort || (state_q == ST_M_TAIL && edge_tick)) begin
                ss_drv_q <= 1'b0;
            end else if (state_q == ST_M_LEAD && edge_tick) begin
                ss_drv_q <= 1'b1;
            end
            if (!is_master) begin
                demote_q <= 1'b0;
            end else if (fault_hit) begin
                demote_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        done       = (state_q == ST_DONE);
        busy       = (state_q != ST_IDLE);
        mode_fault = fault_q;
        as_master  = role_m;
        sck_out    = cpol ^ sck_ph_q;
        sck_oe     = enable & role_m;
        ss_out     = ~ss_drv_q;
        ss_oe      = enable & role_m & fault_en & ss_out_en;
    end

endmodule

// File: rtl/spi_shift_core_chk.sv
module spi_shift_core_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic cpol,
    input logic one_wire,
    input logic pin_oe,
    input logic ss_in,
    input logic done,
    input logic mode_fault,
    input logic as_master,
    input logic busy,
    input logic sck_out,
    input logic sck_oe,
    input logic mosi_oe,
    input logic miso_oe,
    input logic ss_out,
    input logic ss_oe
);

    // R10: completion is a one-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: fault pulse is single and the role has already dropped
    p_fault_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_fault |-> !as_master ##1 !mode_fault);

    // R2: idle master clock sits at the polarity level
    p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sck_oe) |-> (sck_out == cpol));

    // R11: disabled engine drives nothing
    p_disabled_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!sck_oe && !mosi_oe && !miso_oe && !ss_oe));

    // R5: single-wire with direction bit clear drives no data pin
    p_one_wire_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (one_wire && !pin_oe) |-> (!mosi_oe && !miso_oe));

    // R6: automatic select is released when the result appears
    p_ss_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ss_oe) |-> ss_out);

    // R4: a slave never drives clock or MOSI
    p_slave_pins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !as_master |-> (!sck_oe && !mosi_oe));

    // R9: deselected slave stops driving after the synchroniser delay
    p_slave_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_in && $past(ss_in) && $past(ss_in, 2) && $past(ss_in, 3) && !as_master)
        |-> !miso_oe);

endmodule

bind spi_shift_core spi_shift_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .cpol      (cpol),
    .one_wire  (one_wire),
    .pin_oe    (pin_oe),
    .ss_in     (ss_in),
    .done      (done),
    .mode_fault(mode_fault),
    .as_master (as_master),
    .busy      (busy),
    .sck_out   (sck_out),
    .sck_oe    (sck_oe),
    .mosi_oe   (mosi_oe),
    .miso_oe   (miso_oe),
    .ss_out    (ss_out),
    .ss_oe     (ss_oe)
);

// File: tb/test_spi_shift_core.sv
module test_spi_shift_core;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0, is_master = 1'b0, cpol = 1'b0, cpha = 1'b0;
    logic       lsb_first = 1'b0, one_wire = 1'b0, pin_oe = 1'b0;
    logic       fault_en = 1'b0, ss_out_en = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       start = 1'b0, edge_tick = 1'b0;
    logic       sck_in = 1'b0, mosi_in = 1'b0, miso_in = 1'b0, ss_in = 1'b1;
    logic       sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe, ss_out, ss_oe;
    logic [7:0] rx_byte;
    logic       done, mode_fault, busy, as_master;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_shift_core i_spi_shift_core (
        .clk(clk), .rst_n(rst_n), .enable(enable), .is_master(is_master),
        .cpol(cpol), .cpha(cpha), .lsb_first(lsb_first), .one_wire(one_wire),
        .pin_oe(pin_oe), .fault_en(fault_en), .ss_out_en(ss_out_en),
        .tx_byte(tx_byte), .start(start), .edge_tick(edge_tick),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
        .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
        .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe),
        .ss_in(ss_in), .ss_out(ss_out), .ss_oe(ss_oe),
        .rx_byte(rx_byte), .done(done), .mode_fault(mode_fault),
        .busy(busy), .as_master(as_master)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int bpos(input logic lsb, input int i);
        return lsb ? i : 7 - i;
    endfunction

    // tick generator: one cycle high, five low
    initial begin
        forever begin
            repeat (5) @(negedge clk);
            edge_tick = 1'b1;
            @(negedge clk);
            edge_tick = 1'b0;
        end
    end

    // monitor: compare every completion against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected done", int'(rx_byte), 0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(rx_byte == e, t, int'(rx_byte), int'(e));
                end
            end
        end
    end

    task automatic drive_for_master(input logic ow, input logic b);
        if (ow) begin mosi_in = b;  miso_in = ~b; end
        else    begin miso_in = b;  mosi_in = ~b; end
    endtask

    task automatic drive_for_slave(input logic ow, input logic b);
        if (ow) begin miso_in = b;  mosi_in = ~b; end
        else    begin mosi_in = b;  miso_in = ~b; end
    endtask

    task automatic master_xfer(input logic cp, input logic ph, input logic lsb,
                               input logic ow, input logic auto_ss,
                               input logic [7:0] mtx, input logic [7:0] stx,
                               input string req);
        int k = 0;
        logic last;
        logic [7:0] got = '0;
        is_master = 1'b1; cpol = cp; cpha = ph; lsb_first = lsb;
        one_wire = ow; pin_oe = 1'b0; fault_en = auto_ss; ss_out_en = auto_ss;
        tx_byte = mtx;
        @(negedge clk);
        check(sck_out == cp, "R2 idle clock level", int'(sck_out), int'(cp));
        if (auto_ss) begin
            check(ss_oe && ss_out, "R6 select idle high", int'({ss_oe, ss_out}), 3);
        end
        drive_for_master(ow, stx[bpos(lsb, 0)]);
        exp_q.push_back(stx);
        tag_q.push_back(req);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        last = cp;
        for (int guard = 0; guard < 400 && k < 16; guard++) begin
            @(negedge clk);
            if (sck_out != last) begin
                last = sck_out;
                if (k == 0 && auto_ss) begin
                    check(ss_out == 1'b0, "R6 select low before first edge", int'(ss_out), 0);
                end
                if ((k % 2) == int'(ph)) begin
                    got[bpos(lsb, k / 2)] = mosi_out;
                end else begin
                    int idx;
                    idx = ph ? k / 2 : (k + 1) / 2;
                    if (idx < 8) drive_for_master(ow, stx[bpos(lsb, idx)]);
                end
                k++;
            end
        end
        check(k == 16, "R2 edge count", k, 16);
        if (ow) begin
            check(mosi_oe == 1'b0 && miso_oe == 1'b0, "R5 master pin direction",
                  int'({mosi_oe, miso_oe}), 0);
        end else begin
            check(got == mtx, {req, " master sent"}, int'(got), int'(mtx));
        end
        for (int w = 0; w < 40 && busy; w++) @(negedge clk);
        if (auto_ss) begin
            check(ss_out == 1'b1, "R6 select released", int'(ss_out), 1);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic slave_xfer(input logic cp, input logic ph, input logic lsb,
                              input logic ow, input logic [7:0] stx,
                              input logic [7:0] mtx, input string req);
        logic [7:0] got = '0;
        is_master = 1'b0; cpol = cp; cpha = ph; lsb_first = lsb;
        one_wire = ow; pin_oe = 1'b0; fault_en = 1'b0; ss_out_en = 1'b0;
        tx_byte = stx;
        sck_in = cp;
        drive_for_slave(ow, mtx[bpos(lsb, 0)]);
        exp_q.push_back(mtx);
        tag_q.push_back(req);
        repeat (4) @(negedge clk);
        ss_in = 1'b0;
        repeat (HALF) @(negedge clk);
        if (!ow) begin
            check(miso_oe == 1'b1, "R9 slave drives when selected", int'(miso_oe), 1);
            if (!ph) begin
                check(miso_out == stx[bpos(lsb, 0)], "R9 first bit before edges",
                      int'(miso_out), int'(stx[bpos(lsb, 0)]));
            end
        end
        for (int k = 0; k < 16; k++) begin
            if ((k % 2) == int'(ph)) begin
                if (ow) begin
                    check(miso_oe == 1'b0, "R5 slave pin direction", int'(miso_oe), 0);
                end
                got[bpos(lsb, k / 2)] = miso_out;
                sck_in = ~sck_in;
            end else begin
                int idx;
                sck_in = ~sck_in;
                idx = ph ? k / 2 : (k + 1) / 2;
                if (idx < 8) drive_for_slave(ow, mtx[bpos(lsb, idx)]);
            end
            repeat (HALF) @(negedge clk);
        end
        repeat (HALF) @(negedge clk);
        ss_in = 1'b1;
        repeat (8) @(negedge clk);
        if (!ow) check(got == stx, {req, " slave sent"}, int'(got), int'(stx));
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state, disabled
        check(!busy && !done && !mode_fault, "R10 reset idle", int'({busy, done, mode_fault}), 0);
        check(ss_out == 1'b1, "R6 reset select high", int'(ss_out), 1);
        is_master = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(!busy, "R11 start ignored while disabled", int'(busy), 0);
        check(!sck_oe && !mosi_oe && !miso_oe && !ss_oe, "R11 no drive while disabled",
              int'({sck_oe, mosi_oe, miso_oe, ss_oe}), 0);
        enable = 1'b1;

        master_xfer(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, 8'h3C, "R1 R3 R4 master mode0 msb");
        master_xfer(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h81, 8'hD2, "R1 R3 master mode3 lsb");
        ss_in = 1'b0;
        master_xfer(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h5E, 8'h96, "R8 master fault off ss low");
        check(ss_oe == 1'b0, "R8 select not driven", int'(ss_oe), 0);
        ss_in = 1'b1;
        master_xfer(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h6B, "R5 master single wire rx");

        slave_xfer(1'b0, 1'b0, 1'b0, 1'b0, 8'hC3, 8'h1F, "R1 R4 R9 slave mode0 msb");
        slave_xfer(1'b1, 1'b1, 1'b1, 1'b0, 8'h4D, 8'hE8, "R1 R3 slave mode3 lsb");
        slave_xfer(1'b1, 1'b0, 1'b0, 1'b0, 8'h27, 8'hB4, "R3 slave mode2");
        slave_xfer(1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h59, "R5 slave single wire rx");

        // R9: deselected slave ignores the clock
        ss_in = 1'b1;
        for (int k = 0; k < 16; k++) begin
            sck_in = ~sck_in;
            repeat (4) @(negedge clk);
            if (k == 15) begin
                check(!miso_oe && !busy, "R9 deselected slave quiet",
                      int'({miso_oe, busy}), 0);
            end
        end

        // R7: mode fault aborts a master transfer
        begin
            bit seen = 0;
            is_master = 1'b1; fault_en = 1'b1; ss_out_en = 1'b0; one_wire = 1'b0;
            cpol = 1'b0; cpha = 1'b0;
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (20) @(negedge clk);
            check(busy, "R7 transfer running before fault", int'(busy), 1);
            ss_in = 1'b0;
            for (int w = 0; w < 10; w++) begin
                @(negedge clk);
                if (mode_fault) seen = 1;
            end
            check(seen, "R7 fault pulse", int'(seen), 1);
            check(!as_master && !sck_oe && !mosi_oe, "R7 master released",
                  int'({as_master, sck_oe, mosi_oe}), 0);
            ss_in = 1'b1;
            repeat (8) @(negedge clk);
            check(!as_master, "R7 stays slave", int'(as_master), 0);
            is_master = 1'b0;
            @(negedge clk);
            is_master = 1'b1;
            @(negedge clk);
            check(as_master, "R7 role restored", int'(as_master), 1);
        end

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R10 all completions seen", exp_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule